// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block manages low-power states for a small microcontroller core. A CPU bus writes and reads an 8-bit control byte that holds a sleep-enable flag, a 3-bit mode code and four interrupt-sense bits. The controller stores the sense bits but does not interpret them. The core pulses `sleep_instr` when it executes its sleep instruction. If the enable flag is set at that moment, the controller latches the resolved mode. It then drops the clock enables for the domains that mode stops: CPU, I/O, ADC, asynchronous timer and main oscillator.

An enabled interrupt (`irq_pend`) wakes the core. For modes that stop the oscillator, the controller first waits a parameterised start-up count. It then holds the core halted for a fixed number of extra cycles, four by default. Next it releases the core and pulses `irq_go` so the interrupt is serviced. A synchronous reset during sleep returns the controller straight to the running state with every clock enabled and no wake halt. The controller never touches memory contents, so state survives sleep.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: After reset the control byte reads 0. A bus write stores all 8 bits, and `bus_rdata` shows the stored byte from the next cycle. Bit 6 is the sleep enable. Bits 7, 5 and 4 form the mode code {b7,b5,b4}. Bits 3..0 are stored only.
- R2: A `sleep_instr` pulse while bit 6 is 0 has no effect. `pm_status` stays running (2'b00), `core_halt` stays 0 and all clock enables stay 1.
- R3: A `sleep_instr` pulse in the running state with bit 6 set gives `pm_status` = asleep (2'b01) and `core_halt` = 1 on the next cycle.
- R4: While asleep, the enables {cpu,io,adc,async,osc} are: code 000 gives 01111; 001 gives 00111; 010 gives 00000; 011 gives 00010; 110 gives 00001; 111 gives 00011.
- R5: Reserved codes 100 and 101 act as code 000.
- R6: Codes 110 and 111 take effect only when `xtal_ext` is 1 at sleep entry. Otherwise they act as code 000.
- R7: An `irq_pend` sampled while asleep moves `pm_status` to waking (2'b10) on the next cycle. Waking lasts D + WAKE_HALT cycles, where D = STARTUP_CYC for codes 010 and 011 and 0 otherwise. Then `pm_status` returns to running, with `irq_go` high for exactly that first running cycle.
- R8: In the start-up part of waking, the enables stay as in sleep except that osc is 1. In the halt part, all enables are 1. `core_halt` is 1 exactly when `pm_status` is not running. All enables are 1 while running.
- R9: Reset asserted while asleep gives, on the next cycle, running status, all enables 1, `core_halt` 0, `irq_go` 0 and a control byte of 0.
- R10: `irq_pend` while running and `sleep_instr` while asleep have no effect on `pm_status` or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Control byte write strobe |
| bus_wdata | input | 8 | Control byte write data |
| bus_rdata | output | 8 | Control byte read data |
| sleep_instr | input | 1 | One-cycle pulse: core executed its sleep instruction |
| xtal_ext | input | 1 | External crystal configuration present |
| irq_pend | input | 1 | An enabled interrupt is pending |
| core_halt | output | 1 | Core must not execute |
| irq_go | output | 1 | One-cycle pulse: core may service the wake interrupt |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_run | output | 1 | Main oscillator run request |
| pm_status | output | 2 | 00 running, 01 asleep, 10 waking |

## Verification
The bench builds the block with STARTUP_CYC = 6 and the default WAKE_HALT = 4. Each wake therefore lasts either 10 or 4 cycles, which is short enough for dozens of randomly drawn sleep/wake rounds in every mode code. The two lengths still differ clearly, so a mode that wrongly gets or skips the start-up count is caught. A start-up count of 6 also keeps the start-up phase visible for a gate check on its first cycle before the halt phase begins.

// File: rtl/slp_pwr_pkg.sv
package slp_pwr_pkg;

    localparam int CTRL_W = 8;
    localparam int BIT_SE = 6;
    localparam int BIT_M2 = 7;
    localparam int BIT_M1 = 5;
    localparam int BIT_M0 = 4;

    typedef enum logic [2:0] {
        M_IDLE  = 3'b000,
        M_ADCNR = 3'b001,
        M_PDOWN = 3'b010,
        M_PSAVE = 3'b011,
        M_RSV4  = 3'b100,
        M_RSV5  = 3'b101,
        M_STBY  = 3'b110,
        M_XSTBY = 3'b111
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_WAKE  = 2'b10
    } slp_status_e;

    typedef enum logic [1:0] {
        PH_RUN   = 2'b00,
        PH_SLEEP = 2'b01,
        PH_START = 2'b10,
        PH_HALT  = 2'b11
    } slp_phase_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic async_tmr;
        logic osc;
    } clk_gate_t;

    localparam clk_gate_t GATES_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, async_tmr: 1'b1, osc: 1'b1};

    // Map a raw code to the mode actually used; unsupported codes fall back to idle.
    function automatic slp_mode_e resolve_mode(input logic [2:0] code, input logic xtal);
        slp_mode_e m;
        case (code)
            3'b100, 3'b101: m = M_IDLE;
            3'b110, 3'b111: m = xtal ? slp_mode_e'(code) : M_IDLE;
            default:        m = slp_mode_e'(code);
        endcase
        return m;
    endfunction

    function automatic clk_gate_t mode_gates(input slp_mode_e m);
        clk_gate_t g;
        g = '0;
        case (m)
            M_IDLE:  begin g.io = 1'b1; g.adc = 1'b1; g.async_tmr = 1'b1; g.osc = 1'b1; end
            M_ADCNR: begin g.adc = 1'b1; g.async_tmr = 1'b1; g.osc = 1'b1; end
            M_PSAVE: begin g.async_tmr = 1'b1; end
            M_STBY:  begin g.osc = 1'b1; end
            M_XSTBY: begin g.async_tmr = 1'b1; g.osc = 1'b1; end
            default: g = '0;
        endcase
        return g;
    endfunction

    // Modes that stop the main oscillator need the start-up wait on wake.
    function automatic logic needs_startup(input slp_mode_e m);
        return (m == M_PDOWN) || (m == M_PSAVE);
    endfunction

endpackage

// File: rtl/slp_cfg_reg.sv
module slp_cfg_reg
    import slp_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q,
    output logic              sleep_en,
    output logic [2:0]        mode_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    assign sleep_en  = q[BIT_SE];
    assign mode_code = {q[BIT_M2], q[BIT_M1], q[BIT_M0]};
endmodule

// File: rtl/slp_wake_fsm.sv
module slp_wake_fsm
    import slp_pwr_pkg::*;
#(
    parameter int STARTUP_CYC = 16,
    parameter int WAKE_HALT   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       sleep_en,
    input  slp_mode_e  eff_mode,
    input  logic       irq_pend,
    output slp_phase_e phase,
    output slp_mode_e  held_mode,
    output logic       irq_go
);
    localparam int MAX_CYC = (STARTUP_CYC > WAKE_HALT) ? STARTUP_CYC : WAKE_HALT;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] START_LD = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] HALT_LD  = CNT_W'(WAKE_HALT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_RUN;
            held_mode <= M_IDLE;
            cnt       <= '0;
            irq_go    <= 1'b0;
        end else begin
            irq_go <= 1'b0;
            case (phase)
                PH_RUN: begin
                    if (sleep_req && sleep_en) begin
                        phase     <= PH_SLEEP;
                        held_mode <= eff_mode;
                    end
                end
                PH_SLEEP: begin
                    if (irq_pend) begin
                        if (needs_startup(held_mode)) begin
                            phase <= PH_START;
                            cnt   <= START_LD;
                        end else begin
                            phase <= PH_HALT;
                            cnt   <= HALT_LD;
                        end
                    end
                end
                PH_START: begin
                    if (cnt == '0) begin
                        phase <= PH_HALT;
                        cnt   <= HALT_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase  <= PH_RUN;
                        irq_go <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/slp_gate_dec.sv
module slp_gate_dec
    import slp_pwr_pkg::*;
(
    input  slp_phase_e  phase,
    input  slp_mode_e   held_mode,
    output clk_gate_t   gates,
    output slp_status_e status,
    output logic        core_halt
);
    always_comb begin
        gates     = GATES_ON;
        status    = ST_RUN;
        core_halt = 1'b0;
        case (phase)
            PH_SLEEP: begin
                gates     = mode_gates(held_mode);
                status    = ST_SLEEP;
                core_halt = 1'b1;
            end
            PH_START: begin
                gates     = mode_gates(held_mode);
                gates.osc = 1'b1;
                status    = ST_WAKE;
                core_halt = 1'b1;
            end
            PH_HALT: begin
                status    = ST_WAKE;
                core_halt = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
    import slp_pwr_pkg::*;
#(
    parameter int STARTUP_CYC = 16,
    parameter int WAKE_HALT   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        sleep_instr,
    input  logic        xtal_ext,
    input  logic        irq_pend,
    output logic        core_halt,
    output logic        irq_go,
    output logic        clk_en_cpu,
    output logic        clk_en_io,
    output logic        clk_en_adc,
    output logic        clk_en_async,
    output logic        osc_run,
    output logic [1:0]  pm_status
);
    logic        sleep_en;
    logic [2:0]  mode_code;
    slp_mode_e   eff_mode;
    slp_mode_e   held_mode;
    slp_phase_e  phase;
    clk_gate_t   gates;
    slp_status_e status;

    slp_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .q         (bus_rdata),
        .sleep_en  (sleep_en),
        .mode_code (mode_code)
    );

    assign eff_mode = resolve_mode(mode_code, xtal_ext);

    slp_wake_fsm #(
        .STARTUP_CYC (STARTUP_CYC),
        .WAKE_HALT   (WAKE_HALT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_instr),
        .sleep_en  (sleep_en),
        .eff_mode  (eff_mode),
        .irq_pend  (irq_pend),
        .phase     (phase),
        .held_mode (held_mode),
        .irq_go    (irq_go)
    );

    slp_gate_dec u_dec (
        .phase     (phase),
        .held_mode (held_mode),
        .gates     (gates),
        .status    (status),
        .core_halt (core_halt)
    );

    assign clk_en_cpu   = gates.cpu;
    assign clk_en_io    = gates.io;
    assign clk_en_adc   = gates.adc;
    assign clk_en_async = gates.async_tmr;
    assign osc_run      = gates.osc;
    assign pm_status    = status;
endmodule

// File: rtl/slp_pwr_ctrl_chk.sv
module slp_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_rdata,
    input logic       sleep_instr,
    input logic       irq_pend,
    input logic       core_halt,
    input logic       irq_go,
    input logic       clk_en_cpu,
    input logic       clk_en_io,
    input logic       clk_en_adc,
    input logic       clk_en_async,
    input logic       osc_run,
    input logic [1:0] pm_status
);
    logic [4:0] en_vec;
    assign en_vec = {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_run};

    assert_no_enable_no_sleep_R2: assert property (@(posedge clk) disable iff (rst)
        (pm_status == 2'b00 && sleep_instr && !bus_rdata[6]) |=> (pm_status == 2'b00));

    assert_enter_sleep_R3: assert property (@(posedge clk) disable iff (rst)
        (pm_status == 2'b00 && sleep_instr && bus_rdata[6]) |=> (pm_status == 2'b01 && core_halt));

    assert_wake_starts_R7: assert property (@(posedge clk) disable iff (rst)
        (pm_status == 2'b01 && irq_pend) |=> (pm_status == 2'b10));

    assert_go_after_wake_R7: assert property (@(posedge clk) disable iff (rst)
        irq_go |-> (pm_status == 2'b00 && $past(pm_status) == 2'b10));

    assert_halt_tracks_status_R8: assert property (@(posedge clk) disable iff (rst)
        core_halt == (pm_status != 2'b00));

    assert_running_all_on_R8: assert property (@(posedge clk) disable iff (rst)
        (pm_status == 2'b00) |-> (en_vec == 5'b11111));

    assert_stay_asleep_R10: assert property (@(posedge clk) disable iff (rst)
        (pm_status == 2'b01 && !irq_pend) |=> (pm_status == 2'b01 && $stable(en_vec)));

    assert_reset_exit_R9: assert property (@(posedge clk)
        rst |=> (pm_status == 2'b00 && !irq_go && bus_rdata == 8'h00));
endmodule

bind slp_pwr_ctrl slp_pwr_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_rdata    (bus_rdata),
    .sleep_instr  (sleep_instr),
    .irq_pend     (irq_pend),
    .core_halt    (core_halt),
    .irq_go       (irq_go),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .clk_en_async (clk_en_async),
    .osc_run      (osc_run),
    .pm_status    (pm_status)
);

// File: tb/slp_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module slp_pwr_ctrl_tb_top;
    localparam int STARTUP = 6;
    localparam int HALT    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sleep_instr = 1'b0;
    logic       xtal_ext = 1'b0;
    logic       irq_pend = 1'b0;
    logic       core_halt, irq_go;
    logic       clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_run;
    logic [1:0] pm_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slp_pwr_ctrl #(.STARTUP_CYC(STARTUP), .WAKE_HALT(HALT)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_instr(sleep_instr), .xtal_ext(xtal_ext), .irq_pend(irq_pend),
        .core_halt(core_halt), .irq_go(irq_go), .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_run(osc_run),
        .pm_status(pm_status)
    );

    function automatic logic [4:0] gates_now();
        return {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_run};
    endfunction

    function automatic logic [4:0] exp_gates(input logic [2:0] code, input logic xt);
        case (code)
            3'b000: return 5'b01111;
            3'b001: return 5'b00111;
            3'b010: return 5'b00000;
            3'b011: return 5'b00010;
            3'b110: return xt ? 5'b00001 : 5'b01111;
            3'b111: return xt ? 5'b00011 : 5'b01111;
            default: return 5'b01111;
        endcase
    endfunction

    function automatic int exp_delay(input logic [2:0] code);
        return (code == 3'b010 || code == 3'b011) ? STARTUP : 0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_instr = 1'b1;
        @(negedge clk);
        sleep_instr = 1'b0;
    endtask

    // One full sleep/wake round for a given code, enable flag and crystal setting.
    task automatic round(input logic [2:0] code, input logic se, input logic xt, input logic [3:0] low);
        logic [7:0] v;
        logic [4:0] sg;
        int n;
        v = {code[2], se, code[1:0], low};
        xtal_ext = xt;
        wr(v);
        chk("R1", "readback", 32'(bus_rdata), 32'(v));
        pulse_sleep();
        if (!se) begin
            chk("R2", "status no enable", 32'(pm_status), 0);
            chk("R2", "gates no enable", 32'(gates_now()), 32'h1f);
            chk("R2", "halt no enable", 32'(core_halt), 0);
            return;
        end
        sg = exp_gates(code, xt);
        chk("R3", "status asleep", 32'(pm_status), 1);
        chk("R3", "halt asleep", 32'(core_halt), 1);
        if (code == 3'b100 || code == 3'b101)
            chk("R5", "reserved gates", 32'(gates_now()), 32'(sg));
        else if (code[2:1] == 2'b11)
            chk("R6", "standby gates", 32'(gates_now()), 32'(sg));
        else
            chk("R4", "mode gates", 32'(gates_now()), 32'(sg));
        xtal_ext = ~xt;  // crystal input changes after entry must not matter
        sleep_instr = 1'b1;
        @(negedge clk);
        sleep_instr = 1'b0;
        chk("R10", "sleep while asleep status", 32'(pm_status), 1);
        chk("R10", "sleep while asleep gates", 32'(gates_now()), 32'(sg));
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        n = 0;
        while (pm_status == 2'b10 && n < 100) begin
            n++;
            if (n == 1) begin
                if (exp_delay(code) > 0)
                    chk("R8", "startup gates", 32'(gates_now()), 32'(sg | 5'b00001));
                else
                    chk("R8", "halt gates", 32'(gates_now()), 32'h1f);
            end
            chk("R8", "halt while waking", 32'(core_halt), 1);
            chk("R7", "no early go", 32'(irq_go), 0);
            @(negedge clk);
        end
        chk("R7", "wake length", 32'(n), 32'(exp_delay(code) + HALT));
        chk("R7", "status running", 32'(pm_status), 0);
        chk("R7", "go pulse", 32'(irq_go), 1);
        chk("R8", "gates running", 32'(gates_now()), 32'h1f);
        @(negedge clk);
        chk("R7", "go single", 32'(irq_go), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R7 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset byte", 32'(bus_rdata), 0);
        chk("R8", "reset status", 32'(pm_status), 0);
        chk("R8", "reset gates", 32'(gates_now()), 32'h1f);

        // irq while running has no effect
        irq_pend = 1'b1;
        repeat (3) @(negedge clk);
        irq_pend = 1'b0;
        chk("R10", "irq running status", 32'(pm_status), 0);
        chk("R10", "irq running go", 32'(irq_go), 0);

        // every code, enable set, crystal both ways
        for (int c = 0; c < 8; c++) begin
            round(3'(c), 1'b1, 1'b1, 4'h5);
            round(3'(c), 1'b1, 1'b0, 4'hA);
        end
        round(3'b010, 1'b0, 1'b1, 4'hF);

        // reset while in power-down
        wr(8'b0110_0011);
        pulse_sleep();
        chk("R3", "pd asleep", 32'(pm_status), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "reset status", 32'(pm_status), 0);
        chk("R9", "reset gates", 32'(gates_now()), 32'h1f);
        chk("R9", "reset halt", 32'(core_halt), 0);
        chk("R9", "reset go", 32'(irq_go), 0);
        chk("R9", "reset byte", 32'(bus_rdata), 0);

        // constrained random rounds
        for (int i = 0; i < 40; i++) begin
            round(3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule